// File: doc/BRIEF.md
# Block I/O Transfer Sequencer

This block moves a run of bytes between memory and one I/O port on behalf of a small 8-bit processor. A start pulse loads a byte count, a port address and a 16-bit memory pointer, and a direction bit selects one of two directions. The input direction reads the port and writes memory. The output direction reads memory and writes the port. The block then steps through one iteration per byte. It drives single-cycle request strobes, lowers the pointer and the count after every byte, and stops when the count reaches zero.

Timing follows a machine-cycle model in which one clock is one T-state. An iteration that loops back has five machine cycles, of 4, 5, 3, 4 and 5 T-states. The last iteration drops the fifth machine cycle and takes 16 T-states. Each iteration gives two refresh pulses and a report of its length. A repeating iteration ends at a point where a pending interrupt can cut the block short. The block then stops with the pointer and count already updated, and it raises a flag telling the host to run the block again once the interrupt has been served. The host resumes by starting the block again with the values shown on `count_q` and `ptr_q`.

Top module: `blkio_seq`

## Requirements
- R1: With `dir_out`=0, each iteration first pulses `io_rd` for one clock with `io_addr` equal to the port value. It later pulses `mem_wr` for one clock with `mem_addr` equal to the pointer and `mem_wdata` equal to the byte sampled from `io_rdata` during the `io_rd` clock. At most one of the four strobes is high in any clock.
- R2: With `dir_out`=1, each iteration first pulses `mem_rd` with `mem_addr` equal to the pointer. It later pulses `io_wr` with `io_addr` equal to the port value and `io_wdata` equal to the byte sampled from `mem_rdata` during the `mem_rd` clock.
- R3: After each byte, `ptr_q` and `count_q` each drop by one. `ptr_q` wraps from 0x0000 to 0xFFFF. When a block ends, `count_q` and `ptr_q` hold the start values minus the number of bytes moved.
- R4: The count is tested only after it is lowered, so a start count of 0 gives 256 transfers.
- R5: Each iteration ends with a one-clock `iter_valid` pulse. On a repeating iteration `iter_tstates`=21 and `iter_mcycles`=5. On the final iteration, the one where the count reaches zero, `iter_tstates`=16 and `iter_mcycles`=4. Successive `iter_valid` pulses are exactly as many clocks apart as the later iteration's length.
- R6: Each iteration pulses `refresh` exactly twice, once in each of its first two machine cycles.
- R7: If `irq_pending` is high in the last clock of a repeating iteration, the block stops after that iteration. In that case `done` pulses, `busy` falls, `resume_req` goes high and holds until the next accepted start, and `count_q` and `ptr_q` keep their lowered values.
- R8: `irq_pending` has no effect during a final iteration. The block completes normally with `resume_req`=0.
- R9: `flag_z` and `flag_n` are 0 after reset. At every `iter_valid`, `flag_n`=1 and `flag_z`=1 exactly when the count has reached zero. After an interrupted stop `flag_z`=0.
- R10: `busy` goes high in the clock after an accepted start and falls in the same clock that `done` pulses. A `start` seen while `busy` is high is ignored, and the transfer stream and counts carry on unchanged.
- R11: After reset, `busy`, `done`, `resume_req`, `iter_valid`, `refresh` and all four strobes are 0, and `count_q` and `ptr_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-clock request to begin a block |
| dir_out | input | 1 | 0: port to memory, 1: memory to port |
| init_count | input | 8 | Starting byte count (0 means 256) |
| init_port | input | 8 | Port address |
| init_ptr | input | 16 | Starting memory pointer |
| irq_pending | input | 1 | Interrupt waiting to be taken |
| mem_addr | output | 16 | Memory address (current pointer) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_rdata | input | 8 | Memory read data |
| mem_wdata | output | 8 | Memory write data |
| io_addr | output | 8 | Port address |
| io_rd | output | 1 | Port read strobe |
| io_wr | output | 1 | Port write strobe |
| io_rdata | input | 8 | Port read data |
| io_wdata | output | 8 | Port write data |
| refresh | output | 1 | Refresh cycle pulse |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-clock pulse at block end |
| resume_req | output | 1 | Block was cut short by an interrupt |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Subtract flag |
| iter_valid | output | 1 | One-clock pulse at iteration end |
| iter_tstates | output | 5 | T-states of the iteration just ended |
| iter_mcycles | output | 3 | Machine cycles of the iteration just ended |
| count_q | output | 8 | Current byte count |
| ptr_q | output | 16 | Current memory pointer |

## Verification
The end-of-block decision and the interrupt check fall at the same boundary. A byte that lowers the count to zero can finish while `irq_pending` is already high, and the block must then complete normally and not report an interrupted stop. The bench provokes this by holding `irq_pending` high from before the start of a one-byte block. It judges the outcome by the iteration report, which must be 16 T-states with `resume_req` low and `flag_z` high. It also runs a six-byte block with the same held interrupt, which must stop after one 21-state iteration with the count at five and `resume_req` high.

// File: rtl/blkio_pkg.sv
package blkio_pkg;

  // Machine cycles of a repeating iteration and their lengths in T-states.
  localparam int NUM_MCYC  = 5;
  localparam int REPEAT_TS = 21;
  localparam int FINAL_TS  = 16;

  typedef enum logic {
    XFER_IN  = 1'b0,
    XFER_OUT = 1'b1
  } xfer_dir_e;

  // Length of machine cycle idx, counted from 0.
  function automatic logic [2:0] mcyc_len(input logic [2:0] idx);
    case (idx)
      3'd0:    mcyc_len = 3'd4;
      3'd1:    mcyc_len = 3'd5;
      3'd2:    mcyc_len = 3'd3;
      3'd3:    mcyc_len = 3'd4;
      default: mcyc_len = 3'd5;
    endcase
  endfunction

endpackage

// File: rtl/blkio_timer.sv
module blkio_timer
  import blkio_pkg::*;
#(
  parameter int TS_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            en,
  input  logic            iter_end,
  output logic [2:0]      m_idx,
  output logic [2:0]      t_idx,
  output logic            last_t,
  output logic [TS_W-1:0] tcnt
);

  localparam logic [2:0] M_LAST = 3'(NUM_MCYC - 1);

  assign last_t = (t_idx == (mcyc_len(m_idx) - 3'd1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      m_idx <= '0;
      t_idx <= '0;
      tcnt  <= '0;
    end else if (en) begin
      if (iter_end) begin
        m_idx <= '0;
        t_idx <= '0;
        tcnt  <= '0;
      end else if (last_t) begin
        m_idx <= (m_idx == M_LAST) ? 3'd0 : m_idx + 3'd1;
        t_idx <= '0;
        tcnt  <= tcnt + TS_W'(1);
      end else begin
        t_idx <= t_idx + 3'd1;
        tcnt  <= tcnt + TS_W'(1);
      end
    end
  end

endmodule

// File: rtl/blkio_regs.sv
module blkio_regs #(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 16,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              dec,
  input  logic              init_dir,
  input  logic [CNT_W-1:0]  init_count,
  input  logic [PORT_W-1:0] init_port,
  input  logic [ADDR_W-1:0] init_ptr,
  output logic              dir,
  output logic [CNT_W-1:0]  count,
  output logic [PORT_W-1:0] port,
  output logic [ADDR_W-1:0] ptr,
  output logic              cnt_last
);

  // True when the next lowering brings the count to zero.
  assign cnt_last = (count == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      dir   <= 1'b0;
      count <= '0;
      port  <= '0;
      ptr   <= '0;
    end else if (load) begin
      dir   <= init_dir;
      count <= init_count;
      port  <= init_port;
      ptr   <= init_ptr;
    end else if (dec) begin
      count <= count - CNT_W'(1);
      ptr   <= ptr - ADDR_W'(1);
    end
  end

endmodule

// File: rtl/blkio_bus.sv
module blkio_bus
  import blkio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              dir,
  input  logic [2:0]        m_idx,
  input  logic [2:0]        t_idx,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] io_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              io_rd,
  output logic              io_wr,
  output logic              refresh,
  output logic [DATA_W-1:0] wdata
);

  logic first_acc, second_acc, refr_slot, to_port;

  assign to_port    = (dir == XFER_OUT);
  assign first_acc  = busy && (m_idx == 3'd2) && (t_idx == 3'd1);
  assign second_acc = busy && (m_idx == 3'd3) && (t_idx == 3'd1);
  assign refr_slot  = busy && (m_idx <= 3'd1) && (t_idx == 3'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rd  <= 1'b0;
      mem_wr  <= 1'b0;
      io_rd   <= 1'b0;
      io_wr   <= 1'b0;
      refresh <= 1'b0;
      wdata   <= '0;
    end else begin
      mem_rd  <= first_acc && to_port;
      io_rd   <= first_acc && !to_port;
      io_wr   <= second_acc && to_port;
      mem_wr  <= second_acc && !to_port;
      refresh <= refr_slot;
      if (mem_rd)
        wdata <= mem_rdata;
      else if (io_rd)
        wdata <= io_rdata;
    end
  end

endmodule

// File: rtl/blkio_seq.sv
module blkio_seq
  import blkio_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 16,
  parameter int PORT_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dir_out,
  input  logic [CNT_W-1:0]  init_count,
  input  logic [PORT_W-1:0] init_port,
  input  logic [ADDR_W-1:0] init_ptr,
  input  logic              irq_pending,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [PORT_W-1:0] io_addr,
  output logic              io_rd,
  output logic              io_wr,
  input  logic [DATA_W-1:0] io_rdata,
  output logic [DATA_W-1:0] io_wdata,
  output logic              refresh,
  output logic              busy,
  output logic              done,
  output logic              resume_req,
  output logic              flag_z,
  output logic              flag_n,
  output logic              iter_valid,
  output logic [4:0]        iter_tstates,
  output logic [2:0]        iter_mcycles,
  output logic [CNT_W-1:0]  count_q,
  output logic [ADDR_W-1:0] ptr_q
);

  localparam int TS_W = $clog2(REPEAT_TS + 1);

  logic            load, dec, cnt_last, dir_q;
  logic [2:0]      m_idx, t_idx;
  logic            last_t;
  logic [TS_W-1:0] tcnt;
  logic            end_m4, final_end, rep_end, iter_end;
  logic [DATA_W-1:0] wdata;

  assign load      = start && !busy;
  assign end_m4    = busy && (m_idx == 3'd3) && last_t;
  assign final_end = end_m4 && cnt_last;
  assign rep_end   = busy && (m_idx == 3'(NUM_MCYC - 1)) && last_t;
  assign iter_end  = final_end || rep_end;
  assign dec       = end_m4;

  blkio_timer #(.TS_W(TS_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clear    (load),
    .en       (busy),
    .iter_end (iter_end),
    .m_idx    (m_idx),
    .t_idx    (t_idx),
    .last_t   (last_t),
    .tcnt     (tcnt)
  );

  blkio_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .dec        (dec),
    .init_dir   (dir_out),
    .init_count (init_count),
    .init_port  (init_port),
    .init_ptr   (init_ptr),
    .dir        (dir_q),
    .count      (count_q),
    .port       (io_addr),
    .ptr        (ptr_q),
    .cnt_last   (cnt_last)
  );

  blkio_bus #(.DATA_W(DATA_W)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .dir       (dir_q),
    .m_idx     (m_idx),
    .t_idx     (t_idx),
    .mem_rdata (mem_rdata),
    .io_rdata  (io_rdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .refresh   (refresh),
    .wdata     (wdata)
  );

  assign mem_addr  = ptr_q;
  assign mem_wdata = wdata;
  assign io_wdata  = wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy         <= 1'b0;
      done         <= 1'b0;
      resume_req   <= 1'b0;
      flag_z       <= 1'b0;
      flag_n       <= 1'b0;
      iter_valid   <= 1'b0;
      iter_tstates <= '0;
      iter_mcycles <= '0;
    end else begin
      done       <= 1'b0;
      iter_valid <= 1'b0;
      if (load) begin
        busy       <= 1'b1;
        resume_req <= 1'b0;
      end
      if (end_m4) begin
        flag_z <= cnt_last;
        flag_n <= 1'b1;
      end
      if (iter_end) begin
        iter_valid   <= 1'b1;
        iter_tstates <= 5'(tcnt + TS_W'(1));
        iter_mcycles <= m_idx + 3'd1;
      end
      if (final_end) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (rep_end && irq_pending) begin
        busy       <= 1'b0;
        done       <= 1'b1;
        resume_req <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/blkio_seq_chk.sv
module blkio_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       io_rd,
  input logic       io_wr,
  input logic       refresh,
  input logic       busy,
  input logic       done,
  input logic       resume_req,
  input logic       flag_z,
  input logic       flag_n,
  input logic       iter_valid,
  input logic [4:0] iter_tstates,
  input logic [2:0] iter_mcycles,
  input logic [7:0] count_q
);

  assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr, io_rd, io_wr}));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    busy |=> (count_q == $past(count_q) || count_q == ($past(count_q) - 8'd1)));

  assert_final_len_R5: assert property (@(posedge clk) disable iff (rst)
    (iter_valid && flag_z) |-> (iter_tstates == 5'd16 && iter_mcycles == 3'd4));

  assert_repeat_len_R5: assert property (@(posedge clk) disable iff (rst)
    (iter_valid && !flag_z) |-> (iter_tstates == 5'd21 && iter_mcycles == 3'd5));

  assert_refresh_apart_R6: assert property (@(posedge clk) disable iff (rst)
    refresh |-> !(mem_rd || mem_wr || io_rd || io_wr));

  assert_resume_stop_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(resume_req) |-> (done && !busy && !flag_z));

  assert_sub_flag_R9: assert property (@(posedge clk) disable iff (rst)
    iter_valid |-> flag_n);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

bind blkio_seq blkio_seq_chk i_chk (.*);

// File: tb/test_blkio_seq.sv
module test_blkio_seq;

  logic        clk = 1'b0;
  logic        rst;
  logic        start, dir_out, irq_pending;
  logic [7:0]  init_count, init_port;
  logic [15:0] init_ptr;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, io_rd, io_wr;
  logic [7:0]  mem_rdata, mem_wdata, io_rdata, io_wdata, io_addr;
  logic        refresh, busy, done, resume_req, flag_z, flag_n, iter_valid;
  logic [4:0]  iter_tstates;
  logic [2:0]  iter_mcycles;
  logic [7:0]  count_q;
  logic [15:0] ptr_q;

  always #2 clk = ~clk;

  blkio_seq i_blkio_seq (.*);

  localparam int K_IORD = 0, K_MWR = 1, K_MRD = 2, K_IOWR = 3, K_ITER = 4;

  typedef struct {
    int          kind;
    logic [15:0] addr;
    logic [7:0]  data;
    int          ts;
    bit          fin;
    bit          res;
  } item_t;

  item_t q[$];
  int    nchk = 0, nfail = 0;
  int    cyc = 0;
  logic [7:0] mem [0:65535];
  logic [7:0] ioval = 8'h90;
  logic [7:0] io_next = 8'h90;
  bit    io_bump = 0;
  int    rcnt = 0;
  int    last_iv = 0;
  bit    prev_rep = 0;

  assign mem_rdata = mem[mem_addr];
  assign io_rdata  = ioval;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  task automatic push(input int k, input logic [15:0] a, input logic [7:0] d,
                      input int ts, input bit fin, input bit res);
    item_t it;
    it.kind = k; it.addr = a; it.data = d; it.ts = ts; it.fin = fin; it.res = res;
    q.push_back(it);
  endtask

  // Monitor: pops expected items and compares them with what the design does.
  task automatic pop_cmp(input int k, input logic [15:0] a, input logic [7:0] d,
                         input bit has_d, input string tag);
    item_t it;
    if (q.size() == 0) begin
      check(0, tag, "unexpected event", k, -1);
      return;
    end
    it = q.pop_front();
    check(it.kind == k, tag, "event kind", k, it.kind);
    check(it.addr == a, tag, "address", a, it.addr);
    if (has_d) check(it.data == d, tag, "data", d, it.data);
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (io_bump && !io_rd) begin
        ioval   = ioval + 8'd1;
        io_bump = 0;
      end
      if (refresh) rcnt++;
      if (io_rd) begin
        pop_cmp(K_IORD, {8'h00, io_addr}, 8'h00, 0, "R1");
        io_bump = 1;
      end
      if (mem_wr) begin
        pop_cmp(K_MWR, mem_addr, mem_wdata, 1, "R1");
        mem[mem_addr] = mem_wdata;
      end
      if (mem_rd) pop_cmp(K_MRD, mem_addr, 8'h00, 0, "R2");
      if (io_wr)  pop_cmp(K_IOWR, {8'h00, io_addr}, io_wdata, 1, "R2");
      if (iter_valid) begin
        item_t it;
        if (q.size() == 0) begin
          check(0, "R5", "unexpected iteration end", 0, 1);
        end else begin
          it = q.pop_front();
          check(it.kind == K_ITER, "R5", "event kind", K_ITER, it.kind);
          check(int'(iter_tstates) == it.ts, "R5", "iter_tstates", iter_tstates, it.ts);
          check(int'(iter_mcycles) == ((it.ts == 16) ? 4 : 5), "R5", "iter_mcycles",
                iter_mcycles, (it.ts == 16) ? 4 : 5);
          if (prev_rep)
            check(cyc - last_iv == it.ts, "R5", "iteration spacing", cyc - last_iv, it.ts);
          check(rcnt == 2, "R6", "refresh pulses", rcnt, 2);
          check(done == (it.fin || it.res), "R10", "done", done, it.fin || it.res);
          check(busy == !(it.fin || it.res), "R10", "busy", busy, !(it.fin || it.res));
          check(resume_req == it.res, "R7", "resume_req", resume_req, it.res);
          check(flag_z == it.fin, "R9", "flag_z", flag_z, it.fin);
          check(flag_n == 1'b1, "R9", "flag_n", flag_n, 1);
          prev_rep = !(it.fin || it.res);
        end
        last_iv = cyc;
        rcnt = 0;
      end
    end
  end

  // Driver: predicts the whole block, then starts it and waits for the end.
  task automatic run_block(input bit d, input logic [7:0] c, input logic [7:0] p,
                           input logic [15:0] a, input bit irq, input bit poke,
                           input string tag);
    int          n;
    bit          res;
    bit          fin;
    bit          seen;
    logic [7:0]  cnt;
    logic [15:0] ptr;
    cnt = c; ptr = a; res = 0;
    n = (c == 8'd0) ? 256 : int'(c);
    if (irq && n > 1) begin n = 1; res = 1; end
    for (int i = 0; i < n; i++) begin
      if (!d) begin
        push(K_IORD, {8'h00, p}, 8'h00, 0, 0, 0);
        push(K_MWR, ptr, io_next, 0, 0, 0);
        io_next = io_next + 8'd1;
      end else begin
        push(K_MRD, ptr, 8'h00, 0, 0, 0);
        push(K_IOWR, {8'h00, p}, mem[ptr], 0, 0, 0);
      end
      cnt = cnt - 8'd1;
      ptr = ptr - 16'd1;
      fin = (cnt == 8'd0);
      push(K_ITER, 16'h0, 8'h0, fin ? 16 : 21, fin, res);
    end
    prev_rep = 0;
    @(negedge clk);
    dir_out = d; init_count = c; init_port = p; init_ptr = a;
    irq_pending = irq; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10", "busy after start", busy, 1);
    seen = 0;
    for (int w = 0; w < 8000 && !seen; w++) begin
      @(negedge clk);
      if (poke && w == 40) begin
        start = 1'b1; dir_out = ~d; init_count = 8'd3; init_ptr = 16'h1234;
      end else begin
        start = 1'b0;
      end
      if (done) seen = 1;
    end
    check(seen, tag, "block finished", seen, 1);
    @(negedge clk);
    irq_pending = 1'b0;
    check(count_q == cnt, "R3", "count_q after block", count_q, cnt);
    check(ptr_q == ptr, "R3", "ptr_q after block", ptr_q, ptr);
    check(q.size() == 0, tag, "expected events left", q.size(), 0);
    check(resume_req == res, "R7", "resume_req held", resume_req, res);
    q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", "run timed out", cyc, 150000);
    finish_up();
  end

  initial begin
    for (int i = 0; i < 65536; i++) mem[i] = 8'(i) ^ 8'(i >> 8) ^ 8'h3C;
    rst = 1'b1; start = 1'b0; dir_out = 1'b0; irq_pending = 1'b0;
    init_count = '0; init_port = '0; init_ptr = '0;
    repeat (3) @(negedge clk);
    // R11: state right after reset
    check(!busy && !done && !resume_req && !iter_valid && !refresh, "R11",
          "control outputs after reset", {busy, done, resume_req, iter_valid, refresh}, 0);
    check(!mem_rd && !mem_wr && !io_rd && !io_wr, "R11", "strobes after reset",
          {mem_rd, mem_wr, io_rd, io_wr}, 0);
    check(count_q == 8'd0 && ptr_q == 16'd0, "R11", "count/ptr after reset", ptr_q, 0);
    check(!flag_z && !flag_n, "R9", "flags after reset", {flag_z, flag_n}, 0);
    rst = 1'b0;
    @(negedge clk);

    run_block(1'b0, 8'd4, 8'h21, 16'h8003, 0, 0, "R1");
    run_block(1'b1, 8'd5, 8'h7E, 16'h8003, 0, 0, "R2");
    run_block(1'b1, 8'd3, 8'h44, 16'h0001, 0, 0, "R3");
    run_block(1'b0, 8'd1, 8'h10, 16'h4000, 0, 0, "R5");
    // R7: interrupt held from start stops after the first byte
    run_block(1'b0, 8'd6, 8'h33, 16'h2000, 1, 0, "R7");
    check(count_q == 8'd5 && ptr_q == 16'h1FFF, "R7", "state kept for resume", count_q, 5);
    run_block(1'b0, count_q, 8'h33, ptr_q, 0, 0, "R7");
    // R8: interrupt at the final iteration must not cut anything short
    run_block(1'b1, 8'd1, 8'h55, 16'h2000, 1, 0, "R8");
    // R4 and R10: count 0 gives 256 bytes, a second start mid-block is ignored
    run_block(1'b0, 8'd0, 8'h99, 16'h0100, 0, 1, "R4");
    finish_up();
  end

endmodule